// File: doc/BRIEF.md
# MMC Data Block Transfer Engine

This block moves data between a byte stream and the single serial data line of a memory card. A transfer is launched with a one-cycle start pulse that captures the direction, the mode (one block, a counted or open-ended run of blocks, or a continuous stream), the block length in bytes and the block count. Every cycle in which `bit_en` is high is one bit period on the card line: the engine drives `dat_o`/`dat_oe` for outgoing bits and samples `dat_i` at the end of that cycle for incoming ones.

In block modes each block is framed by a low start bit, carries its bytes most significant bit first, and closes with a 16-bit CRC and a high end bit. On writes the engine generates the CRC, then releases the line, collects the card's status token and waits while the card holds the line low. On reads it checks the CRC and stops the run when a block arrives damaged. Stream mode carries bytes with no CRC until the command side raises `stop`. Write bytes enter on a valid/ready handshake, and read bytes leave as one-cycle `rx_valid` pulses.

Top module: `mmc_data_xfer`

## Requirements
- R1: After reset `busy`, `done`, `dat_oe`, `bit_en`, `tx_ready`, `rx_valid`, `crc_err` and `wr_crc_err` are all 0.
- R2: A written block appears on the line, counting only `bit_en` cycles, as a 0 start bit, then `blk_len` bytes MSB first, then 16 CRC bits MSB first, then a 1 end bit.
- R3: The block CRC uses polynomial x^16+x^12+x^5+1 (0x1021), starts from zero, and covers the data bits only. It is generated on writes and checked on reads.
- R4: After a written block's end bit the line is released (`dat_oe`=0). The engine waits for a 0 on `dat_i`, then takes three status bits and an end bit. Status 010 means accepted. Any other status sets `wr_crc_err`, which stays set until the next start, and ends the transfer after the busy phase.
- R5: After the status token the engine keeps `dat_oe` low while `dat_i` is 0. The next block's start bit follows the first 1 seen.
- R6: `mode`=01 moves `blk_cnt` blocks, each `blk_len` bytes long. A count of 0 runs until a stop.
- R7: In `mode`=01 a `stop` pulse lets the block in progress finish, including its token and busy phase, and then ends the transfer. In `mode`=00 a `stop` pulse has no effect.
- R8: A stream write (`mode`=10) sends a 0 start bit, the accepted bytes with no CRC, and a 1 end bit. The end bit comes at the first byte boundary after a `stop`. A byte accepted in the same cycle as the stop is still sent.
- R9: A read waits for a 0 start bit on `dat_i`, assembles each 8 bits (MSB first) into a byte, and presents it with a one-cycle `rx_valid` pulse. A read never drives the line.
- R10: On a read, a CRC mismatch sets `crc_err`, which stays set until the next start, and the transfer ends after that block.
- R11: A stream read ends after the byte that is in progress when the stop is registered.
- R12: `busy` is high from the cycle after the start until `done`. `done` is a one-cycle pulse.
- R13: When a write byte is not yet available, `bit_en` is low and no data bit is sent until a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| wr_dir | input | 1 | 1 = write to card, 0 = read |
| mode | input | 2 | 00 single, 01 multiple, 10 stream |
| blk_len | input | LEN_W | Bytes per block (at least 1) |
| blk_cnt | input | CNT_W | Blocks in multiple mode, 0 = until stop |
| stop | input | 1 | Stop indication from the command side |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Write byte taken this cycle if valid |
| rx_data | output | 8 | Read byte |
| rx_valid | output | 1 | Read byte pulse |
| bit_en | output | 1 | Card bit period this cycle |
| dat_o | output | 1 | Line value driven |
| dat_oe | output | 1 | Line drive enable |
| dat_i | input | 1 | Line value from card |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| crc_err | output | 1 | Sticky read CRC mismatch |
| wr_crc_err | output | 1 | Sticky rejected write status |

## Verification
A stop indication can land in the same cycle as a write byte handshake in stream mode. The bench raises `stop` exactly on the handshake that delivers the sixth byte, and expects all six bytes and then the end bit on the line with no seventh fetch. In a second case, a stop lands while a counted-free multi-block read is in the middle of its second block. The reference model, which tracks every bit period, requires that block to complete and the run to end with exactly its bytes delivered.

// File: rtl/mmc_xfer_pkg.sv
package mmc_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int TOK_W  = 3;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [TOK_W-1:0] TOK_ACCEPT = 3'b010;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_MULTI  = 2'd1;
  localparam logic [1:0] MODE_STREAM = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WDATA, S_WCRC, S_WEND, S_TOKWAIT, S_TOK, S_BUSY,
    S_RWAIT, S_RDATA, S_RCRC, S_REND, S_DONE
  } xfer_state_e;
endpackage

// File: rtl/mmc_xfer_crc16.sv
module mmc_xfer_crc16
  import mmc_xfer_pkg::*;
#(
  parameter int W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         upd,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[W-1] ^ bit_in;
  assign crc_o = crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '0;
    end else if (upd) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end else if (shift) begin
      crc_q <= {crc_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mmc_xfer_tok.sv
module mmc_xfer_tok
  import mmc_xfer_pkg::*;
#(
  parameter int W = TOK_W,
  parameter logic [W-1:0] ACCEPT = TOK_ACCEPT
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic accepted
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= {sh_q[W-2:0], bit_in};
    end
  end

  assign accepted = (sh_q == ACCEPT);
endmodule

// File: rtl/mmc_data_xfer.sv
module mmc_data_xfer
  import mmc_xfer_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_dir,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             bit_en,
  output logic             dat_o,
  output logic             dat_oe,
  input  logic             dat_i,
  output logic             busy,
  output logic             done,
  output logic             crc_err,
  output logic             wr_crc_err
);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int CIDX_W = $clog2(CRC_W);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [CIDX_W-1:0] LAST_CRC = CIDX_W'(CRC_W - 1);

  xfer_state_e        st;
  logic               wr_q;
  logic [1:0]         mode_q;
  logic [LEN_W-1:0]   len_q, byte_cnt;
  logic [CNT_W-1:0]   cnt_q, blk_done;
  logic               stop_pend, have_byte;
  logic [BYTE_W-1:0]  sh;
  logic [BIT_W-1:0]   bit_idx;
  logic [CIDX_W-1:0]  crc_idx;
  logic [1:0]         tok_idx;
  logic [CRC_W-1:0]   crc;
  logic               tok_ok, is_stream, last_blk, stall;
  logic               crc_clr, crc_upd, crc_shift, crc_bit, tok_clr, tok_sh;

  assign is_stream = (mode_q == MODE_STREAM);
  assign last_blk  = (mode_q == MODE_SINGLE) || stop_pend ||
                     ((cnt_q != '0) && (CNT_W'(blk_done + 1'b1) == cnt_q));

  assign stall    = (st == S_WDATA) && !have_byte;
  assign tx_ready = wr_q && ((st == S_WSTART) || (st == S_WDATA)) && !have_byte &&
                    !(is_stream && stop_pend);
  assign bit_en   = (st != S_IDLE) && (st != S_DONE) && !stall;
  assign dat_oe   = (st == S_WSTART) || (st == S_WDATA) || (st == S_WCRC) || (st == S_WEND);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  always_comb begin
    case (st)
      S_WSTART: dat_o = 1'b0;
      S_WDATA:  dat_o = sh[BYTE_W-1];
      S_WCRC:   dat_o = crc[CRC_W-1];
      default:  dat_o = 1'b1;
    endcase
  end

  assign crc_clr   = (st == S_WSTART) || (st == S_RWAIT);
  assign crc_upd   = ((st == S_WDATA) && have_byte) || (st == S_RDATA) || (st == S_RCRC);
  assign crc_shift = (st == S_WCRC);
  assign crc_bit   = wr_q ? sh[BYTE_W-1] : dat_i;
  assign tok_clr   = (st == S_TOKWAIT);
  assign tok_sh    = (st == S_TOK) && (tok_idx != 2'd3);

  mmc_xfer_crc16 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd), .shift(crc_shift),
    .bit_in(crc_bit), .crc_o(crc)
  );

  mmc_xfer_tok u_tok (
    .clk(clk), .rst(rst), .clr(tok_clr), .shift_en(tok_sh),
    .bit_in(dat_i), .accepted(tok_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      wr_q <= 1'b0;
      mode_q <= MODE_SINGLE;
      len_q <= '0;
      cnt_q <= '0;
      byte_cnt <= '0;
      blk_done <= '0;
      stop_pend <= 1'b0;
      have_byte <= 1'b0;
      sh <= '0;
      bit_idx <= '0;
      crc_idx <= '0;
      tok_idx <= '0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      crc_err <= 1'b0;
      wr_crc_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (stop && (st != S_IDLE)) stop_pend <= 1'b1;
      if (tx_ready && tx_valid) begin
        sh <= tx_data;
        have_byte <= 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          wr_q <= wr_dir;
          mode_q <= mode;
          len_q <= blk_len;
          cnt_q <= blk_cnt;
          stop_pend <= 1'b0;
          crc_err <= 1'b0;
          wr_crc_err <= 1'b0;
          blk_done <= '0;
          have_byte <= 1'b0;
          st <= wr_dir ? S_WSTART : S_RWAIT;
        end
        S_WSTART: begin
          byte_cnt <= '0;
          bit_idx <= '0;
          st <= S_WDATA;
        end
        S_WDATA: begin
          if (have_byte) begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST_BIT) begin
              have_byte <= 1'b0;
              byte_cnt <= byte_cnt + 1'b1;
              if (!is_stream && (byte_cnt == len_q - 1'b1)) begin
                crc_idx <= '0;
                st <= S_WCRC;
              end
            end
          end else if (is_stream && stop_pend) begin
            st <= S_WEND;
          end
        end
        S_WCRC: begin
          crc_idx <= crc_idx + 1'b1;
          if (crc_idx == LAST_CRC) st <= S_WEND;
        end
        S_WEND: st <= is_stream ? S_DONE : S_TOKWAIT;
        S_TOKWAIT: if (!dat_i) begin
          tok_idx <= '0;
          st <= S_TOK;
        end
        S_TOK: begin
          tok_idx <= tok_idx + 1'b1;
          if (tok_idx == 2'd3) begin
            if (!tok_ok) wr_crc_err <= 1'b1;
            st <= S_BUSY;
          end
        end
        S_BUSY: if (dat_i) begin
          blk_done <= blk_done + 1'b1;
          st <= (last_blk || wr_crc_err) ? S_DONE : S_WSTART;
        end
        S_RWAIT: begin
          if ((mode_q != MODE_SINGLE) && stop_pend) begin
            st <= S_DONE;
          end else if (!dat_i) begin
            bit_idx <= '0;
            byte_cnt <= '0;
            st <= S_RDATA;
          end
        end
        S_RDATA: begin
          sh <= {sh[BYTE_W-2:0], dat_i};
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == LAST_BIT) begin
            rx_data <= {sh[BYTE_W-2:0], dat_i};
            rx_valid <= 1'b1;
            byte_cnt <= byte_cnt + 1'b1;
            if (is_stream) begin
              if (stop_pend) st <= S_DONE;
            end else if (byte_cnt == len_q - 1'b1) begin
              crc_idx <= '0;
              st <= S_RCRC;
            end
          end
        end
        S_RCRC: begin
          crc_idx <= crc_idx + 1'b1;
          if (crc_idx == LAST_CRC) st <= S_REND;
        end
        S_REND: begin
          if (crc != '0) begin
            crc_err <= 1'b1;
            st <= S_DONE;
          end else begin
            blk_done <= blk_done + 1'b1;
            st <= last_blk ? S_DONE : S_RWAIT;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_q) |-> !dat_oe); // R9
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BUSY) && !dat_i) |=> !dat_oe); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_CRC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !((st == S_IDLE) && start)) |=> crc_err); // R10
  AST_WR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wr_crc_err && !((st == S_IDLE) && start)) |=> wr_crc_err); // R4
  AST_BLK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (busy && (mode_q == MODE_MULTI) && (cnt_q != '0)) |-> (blk_done <= cnt_q)); // R6
  AST_STREAM_NO_CRC: assert property (@(posedge clk) disable iff (rst)
    ((st == S_WCRC) || (st == S_RCRC)) |-> !is_stream); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stall && !tx_valid && !stop_pend) |=> !bit_en); // R13
endmodule

// File: tb/mmc_data_xfer_tb_top.sv
module mmc_data_xfer_tb_top;
  localparam int LEN_W = 12;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, wr_dir = 1'b0, stop = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [CNT_W-1:0] blk_cnt = '0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic dat_i = 1'b1;
  logic tx_ready, rx_valid, bit_en, dat_o, dat_oe, busy, done, crc_err, wr_crc_err;
  logic [7:0] rx_data;

  mmc_data_xfer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .wr_dir(wr_dir), .mode(mode),
    .blk_len(blk_len), .blk_cnt(blk_cnt), .stop(stop), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .bit_en(bit_en), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i), .busy(busy),
    .done(done), .crc_err(crc_err), .wr_crc_err(wr_crc_err)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  // reference model state
  bit   exp_q[$];
  int   card_q[$];
  logic [7:0] rx_exp[$];
  int   wph, mbits, crc_n, blocks_seen, accepted, rx_count, done_cnt;
  int   m_len, stop_at_acc, stop_at_rx, tx_seed;
  bit   m_stream, stop_sent, adv_pend, last_busy, wr_act, gap_en;
  logic [15:0] mcrc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
    return {c[14:0], 1'b0} ^ (((c[15] ^ b) != 1'b0) ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [7:0] bval(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    case (wph)
      0: begin chk(b == 1'b0, "R2 start bit", b, 0); mcrc = '0; mbits = 0; wph = 1; end
      1: begin
        if (exp_q.size() == 0) begin
          if (m_stream && stop_sent) begin
            chk(b == 1'b1, "R8 stream end bit", b, 1); wph = 4;
          end else begin
            chk(1'b0, "R13 bit sent without byte", b, 0);
          end
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(b == e, "R2 data bit", b, e);
          mcrc = crc_step(mcrc, e);
          mbits++;
          if (!m_stream && mbits == 8 * m_len) begin wph = 2; crc_n = 0; end
        end
      end
      2: begin
        chk(b == mcrc[15 - crc_n], "R3 crc bit", b, mcrc[15 - crc_n]);
        crc_n++;
        if (crc_n == 16) wph = 3;
      end
      3: begin chk(b == 1'b1, "R2 end bit", b, 1); blocks_seen++; wph = 0; end
      default: chk(1'b0, "R8 bit after end", b, 0);
    endcase
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      stop = 1'b0;
      if (adv_pend) begin tx_data = bval(tx_seed + accepted); adv_pend = 0; end
      tx_valid = wr_act && (!gap_en || (cyc % 4) != 2);
      if (done) done_cnt++;
      if (bit_en && dat_oe) line_bit(dat_o);
      if (dat_oe && last_busy) chk(1'b0, "R5 drove during busy", 1, 0);
      if (bit_en && !dat_oe) begin
        int v;
        v = (card_q.size() != 0) ? card_q.pop_front() : 1;
        dat_i = (v == 1);
        last_busy = (v == 2);
      end else begin
        last_busy = 0;
      end
      if (tx_valid && tx_ready) begin
        for (int k = 7; k >= 0; k--) exp_q.push_back(tx_data[k]);
        accepted++;
        adv_pend = 1;
        if (stop_at_acc > 0 && accepted == stop_at_acc) begin stop = 1'b1; stop_sent = 1; end
      end
      if (rx_valid) begin
        if (rx_exp.size() == 0) chk(1'b0, "R9 extra rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = rx_exp.pop_front();
          chk(rx_data == e, "R9 rx byte", rx_data, e);
        end
        rx_count++;
        if (stop_at_rx > 0 && rx_count == stop_at_rx) begin stop = 1'b1; stop_sent = 1; end
      end
    end
  end

  task automatic model_reset();
    exp_q.delete(); card_q.delete(); rx_exp.delete();
    wph = 0; blocks_seen = 0; accepted = 0; rx_count = 0; done_cnt = 0;
    stop_sent = 0; stop_at_acc = 0; stop_at_rx = 0; adv_pend = 0; last_busy = 0;
    wr_act = 0; gap_en = 0;
  endtask

  task automatic add_tok(input logic [2:0] s, input int busy_n);
    card_q.push_back(1); card_q.push_back(1); card_q.push_back(0);
    for (int k = 2; k >= 0; k--) card_q.push_back(int'(s[k]));
    card_q.push_back(1);
    for (int k = 0; k < busy_n; k++) card_q.push_back(2);
    card_q.push_back(1);
  endtask

  task automatic add_rblock(input int len, input int seed, input bit bad, input bit expect_it);
    logic [15:0] c;
    c = '0;
    for (int k = 0; k < 3; k++) card_q.push_back(1);
    card_q.push_back(0);
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      v = bval(seed + i);
      if (expect_it) rx_exp.push_back(v);
      for (int k = 7; k >= 0; k--) begin card_q.push_back(int'(v[k])); c = crc_step(c, v[k]); end
    end
    if (bad) c = c ^ 16'h0001;
    for (int k = 15; k >= 0; k--) card_q.push_back(int'(c[k]));
    card_q.push_back(1);
  endtask

  task automatic launch(input bit wr, input logic [1:0] md, input int len, input int cnt);
    @(negedge clk);
    wr_dir = wr; mode = md; blk_len = LEN_W'(len); blk_cnt = CNT_W'(cnt);
    m_len = len; m_stream = (md == 2'd2);
    wr_act = wr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12 busy after start", busy, 1);
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(1'b0, "R12 done timeout", 0, 1);
    repeat (3) @(negedge clk);
    wr_act = 0;
    chk(done_cnt == 1, {tag, " R12 one done pulse"}, done_cnt, 1);
    chk(busy == 1'b0, {tag, " R12 idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && dat_oe == 0 && bit_en == 0, "R1 idle outputs", busy, 0);
    chk(tx_ready == 0 && rx_valid == 0, "R1 handshakes low", tx_ready, 0);
    chk(crc_err == 0 && wr_crc_err == 0, "R1 flags clear", crc_err, 0);

    // single write, stop ignored (R2 R3 R4 R5 R7)
    model_reset(); tx_seed = 0; tx_data = bval(0);
    add_tok(3'b010, 3); stop_at_acc = 2;
    launch(1, 2'd0, 4, 0);
    wait_done("single-wr");
    chk(blocks_seen == 1, "R7 single ignores stop", blocks_seen, 1);
    chk(accepted == 4, "R2 bytes fetched", accepted, 4);
    chk(wph == 0, "R2 framing complete", wph, 0);
    chk(wr_crc_err == 0, "R4 accepted token", wr_crc_err, 0);

    // counted multi write with gaps and varied busy (R5 R6 R13)
    model_reset(); tx_seed = 50; tx_data = bval(50); gap_en = 1;
    add_tok(3'b010, 2); add_tok(3'b010, 0); add_tok(3'b010, 5);
    launch(1, 2'd1, 3, 3);
    wait_done("multi-wr");
    chk(blocks_seen == 3, "R6 block count", blocks_seen, 3);
    chk(accepted == 9, "R13 bytes fetched with gaps", accepted, 9);

    // rejected status token (R4)
    model_reset(); tx_seed = 90; tx_data = bval(90);
    add_tok(3'b101, 2);
    launch(1, 2'd1, 2, 3);
    wait_done("reject-wr");
    chk(wr_crc_err == 1, "R4 write crc error flag", wr_crc_err, 1);
    chk(blocks_seen == 1, "R4 transfer ended", blocks_seen, 1);

    // stream write, stop with handshake (R8)
    model_reset(); tx_seed = 130; tx_data = bval(130); gap_en = 1; stop_at_acc = 6;
    launch(1, 2'd2, 1, 0);
    wait_done("stream-wr");
    chk(accepted == 6, "R8 no fetch after stop", accepted, 6);
    chk(wph == 4, "R8 end bit seen", wph, 4);
    chk(exp_q.size() == 0, "R8 accepted byte sent", exp_q.size(), 0);
    chk(wr_crc_err == 0, "R4 flag cleared by start", wr_crc_err, 0);

    // single read good (R3 R9)
    model_reset();
    add_rblock(5, 200, 0, 1);
    launch(0, 2'd0, 5, 0);
    wait_done("single-rd");
    chk(rx_count == 5, "R9 byte count", rx_count, 5);
    chk(crc_err == 0, "R3 read crc ok", crc_err, 0);

    // multi read with bad second block (R10)
    model_reset();
    add_rblock(2, 10, 0, 1); add_rblock(2, 20, 1, 1); add_rblock(2, 30, 0, 0);
    launch(0, 2'd1, 2, 3);
    wait_done("bad-rd");
    chk(crc_err == 1, "R10 crc error flag", crc_err, 1);
    chk(rx_count == 4, "R10 abort after block", rx_count, 4);

    // open-ended multi read stopped mid block (R6 R7 R10)
    model_reset();
    add_rblock(2, 40, 0, 1); add_rblock(2, 50, 0, 1); add_rblock(2, 60, 0, 0); add_rblock(2, 70, 0, 0);
    stop_at_rx = 3;
    launch(0, 2'd1, 2, 0);
    wait_done("open-rd");
    chk(rx_count == 4, "R7 block finishes after stop", rx_count, 4);
    chk(crc_err == 0, "R10 flag cleared by start", crc_err, 0);

    // stream read (R11)
    model_reset();
    card_q.push_back(1); card_q.push_back(1); card_q.push_back(0);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = bval(300 + i);
      if (i < 5) rx_exp.push_back(v);
      for (int k = 7; k >= 0; k--) card_q.push_back(int'(v[k]));
    end
    stop_at_rx = 4;
    launch(0, 2'd2, 1, 0);
    wait_done("stream-rd");
    chk(rx_count == 5, "R11 stream read length", rx_count, 5);
    chk(rx_exp.size() == 0, "R11 all bytes seen", rx_exp.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule